// File: doc/BRIEF.md
# UART Loop Mode Selector

This block sits between a UART channel's transmitter and receiver, the serial pins and the host. It is purely a routing and gating stage. It does not generate baud timing and does not build or take apart characters. A two-bit mode input chooses how the serial lines are connected. A decoded mode is applied in the same cycle it is presented, even when a character is partly sent or received.

The block has three modes. In normal operation the pins connect straight to the transmitter and receiver. In automatic echo the external receive line is sampled on each receiver bit strobe and driven back out on the transmit pin. Parity bits, stop bits and break conditions therefore leave the block exactly as they arrived. While echo is active, the receiver still sees the line and the host can still read received data. Host writes to the transmit holding register are dropped, and the transmitter's empty and ready status bits read as inactive. In local loop-back the transmitter's serial output feeds the receiver, the transmit pin rests at mark and the external receive pin is not used.

Mode codes: 2'b00 normal, 2'b01 automatic echo, 2'b10 local loop-back. Code 2'b11 acts as normal.

Top module: `uart_loop_sel`

## Requirements
- R1: After reset, and until the first receiver strobe, the echoed line value is mark (1): in echo mode `txd_o` reads 1.
- R2: In normal mode (2'b00), `txd_o` equals `tx_ser_i` and `rx_ser_o` equals `rxd_i` in the same cycle.
- R3: In echo mode (2'b01), `txd_o` equals the value `rxd_i` had at the most recent rising clock edge where `rx_tick_i` was 1. Between strobes it holds steady.
- R4: In echo mode, `rx_ser_o` equals `rxd_i`, so the receiver keeps working.
- R5: In echo mode, `tx_wr_o` is 0 whatever `host_wr_i` is, and `stat_tx_empty_o` and `stat_tx_ready_o` are 0. In the other modes these three follow `host_wr_i`, `tx_empty_i` and `tx_ready_i`.
- R6: In loop-back mode (2'b10), `rx_ser_o` equals `tx_ser_i`, `txd_o` is 1 and `rxd_i` has no effect on any output.
- R7: Mode code 2'b11 routes and gates exactly as normal mode.
- R8: A mode change alters routing and gating in the same cycle, with no clock edge needed.
- R9: In every mode `rx_pop_o` follows `host_rd_i`, and `host_rx_data_o` follows `rx_data_i`. `tx_data_o` always follows `host_wdata_i`.
- R10: In echo mode, a received break (line low over many strobes) is echoed as 0 on every strobe. `txd_o` returns to 1 only after a strobe samples the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Loop mode code |
| rxd_i | input | 1 | External serial receive pin |
| txd_o | output | 1 | External serial transmit pin |
| rx_tick_i | input | 1 | Receiver bit-sample strobe |
| rx_ser_o | output | 1 | Serial input to the receiver |
| tx_ser_i | input | 1 | Serial output of the transmitter |
| host_wr_i | input | 1 | Host write to transmit holding register |
| host_wdata_i | input | DATA_W | Host write data |
| tx_wr_o | output | 1 | Gated write strobe to transmitter |
| tx_data_o | output | DATA_W | Write data to transmitter |
| tx_empty_i | input | 1 | Transmitter empty status |
| tx_ready_i | input | 1 | Transmitter ready status |
| stat_tx_empty_o | output | 1 | Transmitter empty status seen by host |
| stat_tx_ready_o | output | 1 | Transmitter ready status seen by host |
| host_rd_i | input | 1 | Host read of received data |
| rx_pop_o | output | 1 | Read strobe to receiver |
| rx_data_i | input | DATA_W | Received data from receiver |
| host_rx_data_o | output | DATA_W | Received data seen by host |

## Verification
The hardest case to reach from the ports is an echo-mode output that depends on an earlier line value, not the present one. Examples are a long break held across many strobes, and a mode switch into echo after the line has moved since the last strobe. The bench drives the mode, line, strobe and host inputs through every combination, in an order that leaves the sampled value and the live line different. It keeps its own record of the last strobed line value and compares against that record. A dedicated sequence holds the line low for many strobes, releases it between strobes, and confirms that the echo stays at 0 until a strobe sees the high level.

// File: rtl/uart_loop_pkg.sv
package uart_loop_pkg;

    typedef enum logic [1:0] {
        LM_NORMAL = 2'b00,
        LM_ECHO   = 2'b01,
        LM_LOOP   = 2'b10,
        LM_SPARE  = 2'b11
    } loop_mode_e;

    typedef struct packed {
        logic echo;
        logic loop;
    } mode_flags_t;

    localparam logic LINE_MARK = 1'b1;

    function automatic mode_flags_t decode_mode(input logic [1:0] code);
        mode_flags_t f;
        f.echo = 1'b0;
        f.loop = 1'b0;
        case (loop_mode_e'(code))
            LM_ECHO: f.echo = 1'b1;
            LM_LOOP: f.loop = 1'b1;
            default: ;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ulm_mode_decode.sv
module ulm_mode_decode
    import uart_loop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode_i,
    output mode_flags_t flags_o
);
    always_comb flags_o = decode_mode(mode_i);

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags_o.echo && flags_o.loop)); // R7
    AST_SPARE_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b11) |-> (flags_o == '0)); // R7
endmodule

// File: rtl/ulm_echo_retimer.sv
module ulm_echo_retimer
    import uart_loop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rxd_i,
    input  logic tick_i,
    output logic echo_o
);
    logic echo_q;

    always_ff @(posedge clk) begin
        if (rst)
            echo_q <= LINE_MARK;
        else if (tick_i)
            echo_q <= rxd_i;
    end

    assign echo_o = echo_q;

    AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(echo_o)); // R3
    AST_ECHO_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (echo_o == $past(rxd_i))); // R10
endmodule

// File: rtl/ulm_line_router.sv
module ulm_line_router
    import uart_loop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  mode_flags_t flags_i,
    input  logic        rxd_i,
    input  logic        tx_ser_i,
    input  logic        echo_i,
    output logic        txd_o,
    output logic        rx_ser_o
);
    always_comb begin
        if (flags_i.loop) begin
            txd_o    = LINE_MARK;
            rx_ser_o = tx_ser_i;
        end else if (flags_i.echo) begin
            txd_o    = echo_i;
            rx_ser_o = rxd_i;
        end else begin
            txd_o    = tx_ser_i;
            rx_ser_o = rxd_i;
        end
    end

    AST_LOOP_TXD_MARK: assert property (@(posedge clk) disable iff (rst)
        flags_i.loop |-> (txd_o == LINE_MARK)); // R6
    AST_ECHO_RX_LIVE: assert property (@(posedge clk) disable iff (rst)
        flags_i.echo |-> (rx_ser_o == rxd_i)); // R4
endmodule

// File: rtl/ulm_host_gate.sv
module ulm_host_gate
    import uart_loop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  mode_flags_t       flags_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              tx_wr_o,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              tx_empty_i,
    input  logic              tx_ready_i,
    output logic              stat_tx_empty_o,
    output logic              stat_tx_ready_o,
    input  logic              host_rd_i,
    output logic              rx_pop_o,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [DATA_W-1:0] host_rx_data_o
);
    logic tx_link_on;

    always_comb begin
        tx_link_on      = !flags_i.echo;
        tx_wr_o         = host_wr_i  & tx_link_on;
        stat_tx_empty_o = tx_empty_i & tx_link_on;
        stat_tx_ready_o = tx_ready_i & tx_link_on;
        tx_data_o       = host_wdata_i;
        rx_pop_o        = host_rd_i;
        host_rx_data_o  = rx_data_i;
    end

    AST_ECHO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        flags_i.echo |-> !tx_wr_o); // R5
    AST_ECHO_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
        flags_i.echo |-> !(stat_tx_empty_o || stat_tx_ready_o)); // R5
    AST_RX_READ_PASS: assert property (@(posedge clk) disable iff (rst)
        rx_pop_o == host_rd_i); // R9
endmodule

// File: rtl/uart_loop_sel.sv
module uart_loop_sel
    import uart_loop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              rxd_i,
    output logic              txd_o,
    input  logic              rx_tick_i,
    output logic              rx_ser_o,
    input  logic              tx_ser_i,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              tx_wr_o,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              tx_empty_i,
    input  logic              tx_ready_i,
    output logic              stat_tx_empty_o,
    output logic              stat_tx_ready_o,
    input  logic              host_rd_i,
    output logic              rx_pop_o,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [DATA_W-1:0] host_rx_data_o
);
    mode_flags_t flags;
    logic        echo_bit;

    ulm_mode_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .flags_o (flags)
    );

    ulm_echo_retimer u_echo (
        .clk    (clk),
        .rst    (rst),
        .rxd_i  (rxd_i),
        .tick_i (rx_tick_i),
        .echo_o (echo_bit)
    );

    ulm_line_router u_route (
        .clk      (clk),
        .rst      (rst),
        .flags_i  (flags),
        .rxd_i    (rxd_i),
        .tx_ser_i (tx_ser_i),
        .echo_i   (echo_bit),
        .txd_o    (txd_o),
        .rx_ser_o (rx_ser_o)
    );

    ulm_host_gate #(.DATA_W(DATA_W)) u_host (
        .clk             (clk),
        .rst             (rst),
        .flags_i         (flags),
        .host_wr_i       (host_wr_i),
        .host_wdata_i    (host_wdata_i),
        .tx_wr_o         (tx_wr_o),
        .tx_data_o       (tx_data_o),
        .tx_empty_i      (tx_empty_i),
        .tx_ready_i      (tx_ready_i),
        .stat_tx_empty_o (stat_tx_empty_o),
        .stat_tx_ready_o (stat_tx_ready_o),
        .host_rd_i       (host_rd_i),
        .rx_pop_o        (rx_pop_o),
        .rx_data_i       (rx_data_i),
        .host_rx_data_o  (host_rx_data_o)
    );

    AST_NORMAL_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |-> (txd_o == tx_ser_i && rx_ser_o == rxd_i)); // R2
    AST_LOOP_FEED: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b10) |-> (rx_ser_o == tx_ser_i)); // R6
    AST_NORMAL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mode_i != 2'b01) |-> (tx_wr_o == host_wr_i)); // R5
endmodule

// File: tb/uart_loop_sel_tb.sv
module uart_loop_sel_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_i = 2'b00;
    logic          rxd_i = 1'b1, rx_tick_i = 1'b0, tx_ser_i = 1'b1;
    logic          host_wr_i = 1'b0, tx_empty_i = 1'b0, tx_ready_i = 1'b0, host_rd_i = 1'b0;
    logic [DW-1:0] host_wdata_i = '0, rx_data_i = '0;
    logic          txd_o, rx_ser_o, tx_wr_o, stat_tx_empty_o, stat_tx_ready_o, rx_pop_o;
    logic [DW-1:0] tx_data_o, host_rx_data_o;

    int n_vec = 0;
    int n_bad = 0;
    logic model_echo = 1'b1;

    always #2 clk = ~clk;

    uart_loop_sel #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .mode_i(mode_i), .rxd_i(rxd_i), .txd_o(txd_o),
        .rx_tick_i(rx_tick_i), .rx_ser_o(rx_ser_o), .tx_ser_i(tx_ser_i),
        .host_wr_i(host_wr_i), .host_wdata_i(host_wdata_i), .tx_wr_o(tx_wr_o),
        .tx_data_o(tx_data_o), .tx_empty_i(tx_empty_i), .tx_ready_i(tx_ready_i),
        .stat_tx_empty_o(stat_tx_empty_o), .stat_tx_ready_o(stat_tx_ready_o),
        .host_rd_i(host_rd_i), .rx_pop_o(rx_pop_o), .rx_data_i(rx_data_i),
        .host_rx_data_o(host_rx_data_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // clock one edge, then update the bench's own record of the strobed line
    task automatic tick_edge();
        logic smp_tick, smp_rxd;
        smp_tick = rx_tick_i;
        smp_rxd  = rxd_i;
        @(posedge clk);
        if (smp_tick) model_echo = smp_rxd;
        @(negedge clk);
    endtask

    task automatic check_all();
        logic echo, loop;
        string tg;
        echo = (mode_i == 2'b01);
        loop = (mode_i == 2'b10);
        tg = loop ? "R6" : echo ? "R3" : (mode_i == 2'b11) ? "R7" : "R2";
        #1;
        chk(tg, int'(txd_o), loop ? 1 : echo ? int'(model_echo) : int'(tx_ser_i));
        chk(echo ? "R4" : tg, int'(rx_ser_o), loop ? int'(tx_ser_i) : int'(rxd_i));
        chk("R5", int'(tx_wr_o), echo ? 0 : int'(host_wr_i));
        chk("R5", int'(stat_tx_empty_o), echo ? 0 : int'(tx_empty_i));
        chk("R5", int'(stat_tx_ready_o), echo ? 0 : int'(tx_ready_i));
        chk("R9", int'(rx_pop_o), int'(host_rd_i));
        chk("R9", int'(host_rx_data_o), int'(rx_data_i));
        chk("R9", int'(tx_data_o), int'(host_wdata_i));
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_echo = 1'b1;
        // R1: reset leaves echo at mark
        mode_i = 2'b01; rxd_i = 1'b0;
        #1 chk("R1", int'(txd_o), 1);
        @(negedge clk);

        // Exhaustive sweep: mode, line, tx serial, write, status, strobe
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b;
                b = pass ? ~v[7:0] : v[7:0];
                mode_i      = b[1:0];
                rxd_i       = b[2];
                tx_ser_i    = b[3];
                host_wr_i   = b[4];
                tx_empty_i  = b[5];
                tx_ready_i  = b[6];
                rx_tick_i   = b[7];
                host_rd_i   = b[2] ^ b[5];
                rx_data_i   = b ^ 8'h5A;
                host_wdata_i = ~b;
                check_all();
                // R8: flip mode mid-cycle, outputs must follow at once
                mode_i = b[1:0] + 2'd1;
                check_all();
                tick_edge();
            end
        end

        // R6: external line ignored in loop-back
        mode_i = 2'b10; rx_tick_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tx_ser_i = i[0];
            rxd_i = i[1];
            #1;
            chk("R6", int'(txd_o), 1);
            chk("R6", int'(rx_ser_o), i[0] ? 1 : 0);
            tick_edge();
        end

        // R10: break held across many strobes, released between strobes
        mode_i = 2'b01; rxd_i = 1'b0; rx_tick_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick_edge();
            #1 chk("R10", int'(txd_o), 0);
        end
        rx_tick_i = 1'b0; rxd_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick_edge();
            #1 chk("R10", int'(txd_o), 0);
        end
        rx_tick_i = 1'b1;
        tick_edge();
        #1 chk("R10", int'(txd_o), 1);
        chk("R10", int'(model_echo), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule